// File: doc/BRIEF.md
# Single-wire bus network-layer ROM decoder

This block sits behind a link-layer monitor of a single-wire, open-drain bus. The monitor hands it one strobe per decoded time slot, carrying the sampled bit, and a separate strobe whenever it recognises a reset pulse followed by a presence window. From that stream the decoder follows the network layer of each transaction. It first assembles the ROM command byte and classifies it. Depending on the command, it then gathers a 64-bit device ROM code, or rebuilds the device address a search selects, or goes straight on to payload bytes.

A search does not send the address as plain bits. Each address position takes three slots: the bit that the devices drive, its complement, and the direction bit that the master writes. The decoder keeps all three streams. The address it reports is made of the direction bits. It also flags any position where both device slots read high, which means no device answered.

Every result appears as a one-cycle valid pulse on its own output. The command code and ROM code are held until the next result. An error level marks a transaction whose command was not recognised.

Top module: `ow_net_decoder`

## Requirements
- R1: A reset strobe (`rst_stb`) returns the decoder to the command phase, discards every partly collected field and search group, and clears `cmd_error` on the next edge. A bit strobe in the same cycle is dropped.
- R2: In the command phase, 8 strobed bits form the command byte, first bit in bit 0. One cycle after the 8th strobe, `cmd_valid` pulses and `cmd_code` holds the byte.
- R3: Command 0x33, 0x55 and 0x69 lead to ROM collection. Command 0xF0 leads to search. Command 0xCC and 0x3C lead directly to the payload phase.
- R4: Any other command raises `cmd_error` in the same cycle as its `cmd_valid` pulse, and `cmd_error` stays high until the next reset strobe. While it is high, every 8 further bits are still reported on `data_valid`/`data_byte` as raw error bytes.
- R5: ROM collection takes 64 bits, first bit in bit 0. Bits [7:0] are the family code, [55:8] the serial number and [63:56] the check byte. `rom_valid` pulses one cycle after the 64th strobe, and the payload phase follows.
- R6: In search, bits come in groups of three, in this order: device bit, complement, master direction. Bit k of the reported `rom_code` is the direction bit of group k. `rom_valid` pulses one cycle after the 64th group, and the payload phase follows.
- R7: `search_nodev` pulses one cycle after the strobe that completes a search group whose device bit and complement were both 1.
- R8: In the payload phase, every 8 strobed bits give one `data_valid` pulse with the byte, first bit in bit 0. This goes on without limit until a reset strobe.
- R9: Each valid output is a single-cycle pulse, and at most one of `cmd_valid`, `rom_valid` and `data_valid` is high in any cycle. `cmd_code` and `rom_code` change only with their own valid pulse. `bit_val` has no effect without `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe for a decoded data slot |
| bit_val | input | 1 | Bit value of the slot, qualified by `bit_stb` |
| rst_stb | input | 1 | One-cycle strobe for a reset/presence event |
| cmd_valid | output | 1 | Command byte complete |
| cmd_code | output | 8 | Last command byte |
| cmd_error | output | 1 | High while the current transaction's command is unrecognised |
| rom_valid | output | 1 | ROM code complete (collected or searched) |
| rom_code | output | 64 | Last ROM code |
| data_valid | output | 1 | Payload or raw error byte complete |
| data_byte | output | 8 | Last payload byte |
| search_nodev | output | 1 | Search group with both device slots high |

## Verification
The assertions watch, on every cycle, the properties that can be seen locally in time. They check that the valid pulses are exclusive and last one cycle, that the held codes change only with their pulse, that `cmd_error` agrees with the command code and stays high until a reset strobe, that a reset strobe silences every output on the next edge, and that the field and search completions never coincide. Only the bench's scenarios can show that the right command leads to the right phase, that 64 bits or 64 triplets rebuild the right address, that byte values come out in the right bit order, and that a reset in the middle of a byte truly discards the partial bits. The bench's reference model tracks these over whole transactions.

// File: rtl/ow_net_pkg.sv
package ow_net_pkg;
  localparam int OW_ROM_W  = 64;
  localparam int OW_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_CMD, ST_ROM, ST_SRCH, ST_XPORT, ST_ERR
  } ow_state_e;

  // Place one bit into a word at a given index.
  function automatic logic [OW_ROM_W-1:0] put_bit(input logic [OW_ROM_W-1:0] w,
                                                  input int unsigned idx,
                                                  input logic b);
    logic [OW_ROM_W-1:0] r;
    r      = w;
    r[idx] = b;
    return r;
  endfunction

  // Mask with the low n bits set.
  function automatic logic [OW_ROM_W-1:0] low_mask(input int unsigned n);
    logic [OW_ROM_W-1:0] m;
    for (int i = 0; i < OW_ROM_W; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == 8'h33) || (c == 8'h55) || (c == 8'hF0) ||
           (c == 8'hCC) || (c == 8'h3C) || (c == 8'h69);
  endfunction

  function automatic ow_state_e cmd_next(input logic [7:0] c);
    case (c)
      8'h33, 8'h55, 8'h69: return ST_ROM;
      8'hF0:               return ST_SRCH;
      8'hCC, 8'h3C:        return ST_XPORT;
      default:             return ST_ERR;
    endcase
  endfunction
endpackage

// File: rtl/ow_bit_collector.sv
module ow_bit_collector
  import ow_net_pkg::*;
#(
  parameter int MAX_W = OW_ROM_W,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] len,
  output logic             done,
  output logic [MAX_W-1:0] field
);
  logic [MAX_W-1:0] acc;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [OW_ROM_W-1:0] ins;

  assign cnt_nx = cnt + 1'b1;
  assign done   = shift && !clear && (cnt_nx == len);
  assign ins    = put_bit(OW_ROM_W'(acc), int'(cnt), bit_in) & low_mask(int'(len));
  assign field  = ins[MAX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clear || done) begin
      acc <= '0;
      cnt <= '0;
    end else if (shift) begin
      acc <= field;
      cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/ow_search_tracker.sv
module ow_search_tracker
  import ow_net_pkg::*;
#(
  parameter int ROM_W = OW_ROM_W,
  localparam int GW = $clog2(ROM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  output logic             grp_done,
  output logic             nodev,
  output logic [ROM_W-1:0] rom_out
);
  logic [ROM_W-1:0] orig_r, comp_r, dir_r;
  logic [1:0]       phase;
  logic [GW-1:0]    gidx;
  logic             dir_slot;
  logic [OW_ROM_W-1:0] dir_ins;

  assign dir_slot = shift && !clear && (phase == 2'd2);
  assign nodev    = dir_slot && orig_r[gidx] && comp_r[gidx];
  assign grp_done = dir_slot && (gidx == GW'(ROM_W - 1));
  assign dir_ins  = put_bit(OW_ROM_W'(dir_r), int'(gidx), bit_in);
  assign rom_out  = dir_ins[ROM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_r <= '0; comp_r <= '0; dir_r <= '0;
      phase  <= '0; gidx   <= '0;
    end else if (clear || grp_done) begin
      orig_r <= '0; comp_r <= '0; dir_r <= '0;
      phase  <= '0; gidx   <= '0;
    end else if (shift) begin
      case (phase)
        2'd0: begin orig_r[gidx] <= bit_in; phase <= 2'd1; end
        2'd1: begin comp_r[gidx] <= bit_in; phase <= 2'd2; end
        default: begin
          dir_r <= rom_out;
          phase <= 2'd0;
          gidx  <= gidx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ow_net_decoder.sv
module ow_net_decoder
  import ow_net_pkg::*;
#(
  parameter int ROM_W  = OW_ROM_W,
  parameter int BYTE_W = OW_BYTE_W,
  localparam int CNT_W = $clog2(ROM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              rst_stb,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_code,
  output logic              cmd_error,
  output logic              rom_valid,
  output logic [ROM_W-1:0]  rom_code,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte,
  output logic              search_nodev
);
  ow_state_e         state;
  logic              col_shift, col_done, srch_shift, srch_done, srch_nodev;
  logic [CNT_W-1:0]  col_len;
  logic [ROM_W-1:0]  col_field, srch_rom;
  logic [BYTE_W-1:0] col_byte;

  assign col_shift  = bit_stb && (state != ST_SRCH);
  assign srch_shift = bit_stb && (state == ST_SRCH);
  assign col_len    = (state == ST_ROM) ? CNT_W'(ROM_W) : CNT_W'(BYTE_W);
  assign col_byte   = col_field[BYTE_W-1:0];

  ow_bit_collector #(.MAX_W(ROM_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(rst_stb), .shift(col_shift),
    .bit_in(bit_val), .len(col_len), .done(col_done), .field(col_field)
  );

  ow_search_tracker #(.ROM_W(ROM_W)) u_srch (
    .clk(clk), .rst_n(rst_n), .clear(rst_stb), .shift(srch_shift),
    .bit_in(bit_val), .grp_done(srch_done), .nodev(srch_nodev), .rom_out(srch_rom)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      cmd_valid <= 1'b0; cmd_code <= '0; cmd_error <= 1'b0;
      rom_valid <= 1'b0; rom_code <= '0;
      data_valid <= 1'b0; data_byte <= '0; search_nodev <= 1'b0;
    end else begin
      cmd_valid    <= 1'b0;
      rom_valid    <= 1'b0;
      data_valid   <= 1'b0;
      search_nodev <= srch_nodev;
      if (rst_stb) begin
        state     <= ST_CMD;
        cmd_error <= 1'b0;
      end else begin
        case (state)
          ST_CMD: if (col_done) begin
            cmd_valid <= 1'b1;
            cmd_code  <= col_byte;
            cmd_error <= !cmd_known(8'(col_byte));
            state     <= cmd_next(8'(col_byte));
          end
          ST_ROM: if (col_done) begin
            rom_valid <= 1'b1;
            rom_code  <= col_field;
            state     <= ST_XPORT;
          end
          ST_SRCH: if (srch_done) begin
            rom_valid <= 1'b1;
            rom_code  <= srch_rom;
            state     <= ST_XPORT;
          end
          default: if (col_done) begin
            data_valid <= 1'b1;
            data_byte  <= col_byte;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_net_checker.sv
module ow_net_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_stb,
  input logic        rst_stb,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic        cmd_error,
  input logic        rom_valid,
  input logic [63:0] rom_code,
  input logic        data_valid,
  input logic        search_nodev,
  input logic        col_done,
  input logic        srch_done
);
  a_r1_reset_silences: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |=> !cmd_error && !cmd_valid && !rom_valid && !data_valid && !search_nodev);

  a_r2_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r4_error_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_error == !(cmd_code inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'h3C, 8'h69})));

  a_r4_error_rises_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_error) |-> cmd_valid);

  a_r4_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_error && !rst_stb) |=> cmd_error);

  a_r7_nodev_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    search_nodev |-> $past(bit_stb && !rst_stb));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, rom_valid, data_valid}));

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_code) |-> cmd_valid);

  a_r9_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_code) |-> rom_valid);

  a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_done, srch_done}));
endmodule

bind ow_net_decoder ow_net_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rst_stb(rst_stb),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_error(cmd_error),
  .rom_valid(rom_valid), .rom_code(rom_code), .data_valid(data_valid),
  .search_nodev(search_nodev), .col_done(col_done), .srch_done(srch_done)
);

// File: tb/test_ow_net_decoder.sv
module test_ow_net_decoder;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, bit_val = 1'b0, rst_stb = 1'b0;
  logic cmd_valid, cmd_error, rom_valid, data_valid, search_nodev;
  logic [7:0] cmd_code, data_byte;
  logic [63:0] rom_code;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ow_net_decoder i_ow_net_decoder (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val), .rst_stb(rst_stb),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_error(cmd_error),
    .rom_valid(rom_valid), .rom_code(rom_code), .data_valid(data_valid),
    .data_byte(data_byte), .search_nodev(search_nodev)
  );

  // Reference model: phase 0 command, 1 rom, 2 search, 3 payload, 4 error
  int m_phase = 0, m_trip = 0, m_grp = 0;
  logic m_dev, m_cmp;
  logic q[$];
  logic [63:0] m_srch = '0;
  logic e_cv = 0, e_err = 0, e_rv = 0, e_dv = 0, e_nd = 0;
  logic [7:0] e_code = '0, e_byte = '0;
  logic [63:0] e_rom = '0;

  function automatic logic [63:0] pack_q(int n);
    logic [63:0] w = '0;
    for (int i = 0; i < n; i++) w[i] = q[i];
    return w;
  endfunction

  task automatic model(input logic stb, input logic v, input logic rs);
    e_cv = 0; e_rv = 0; e_dv = 0; e_nd = 0;
    if (rs) begin
      m_phase = 0; q.delete(); m_trip = 0; m_grp = 0; m_srch = '0; e_err = 0;
    end else if (stb) begin
      if (m_phase == 2) begin
        if (m_trip == 0) m_dev = v;
        else if (m_trip == 1) m_cmp = v;
        else begin
          m_srch[m_grp] = v;
          e_nd = m_dev & m_cmp;
          m_grp++;
          if (m_grp == 64) begin
            e_rv = 1; e_rom = m_srch; m_phase = 3; m_grp = 0; m_srch = '0;
          end
        end
        m_trip = (m_trip + 1) % 3;
      end else begin
        q.push_back(v);
        if (m_phase == 1 && q.size() == 64) begin
          e_rv = 1; e_rom = pack_q(64); q.delete(); m_phase = 3;
        end else if (m_phase != 1 && q.size() == 8) begin
          logic [7:0] b = 8'(pack_q(8));
          q.delete();
          if (m_phase == 0) begin
            e_cv = 1; e_code = b;
            case (b)
              8'h33, 8'h55, 8'h69: m_phase = 1;
              8'hF0:               m_phase = 2;
              8'hCC, 8'h3C:        m_phase = 3;
              default: begin m_phase = 4; e_err = 1; end
            endcase
          end else begin
            e_dv = 1; e_byte = b;
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "cmd_valid", 64'(cmd_valid), 64'(e_cv));
    chk("R2 R9", "cmd_code", 64'(cmd_code), 64'(e_code));
    chk("R4", "cmd_error", 64'(cmd_error), 64'(e_err));
    chk("R5 R6 R3", "rom_valid", 64'(rom_valid), 64'(e_rv));
    chk("R5 R6", "rom_code", rom_code, e_rom);
    chk("R8 R3", "data_valid", 64'(data_valid), 64'(e_dv));
    chk("R8 R4", "data_byte", 64'(data_byte), 64'(e_byte));
    chk("R7", "search_nodev", 64'(search_nodev), 64'(e_nd));
    chk("R9", "valid count", 64'(int'(cmd_valid) + int'(rom_valid) + int'(data_valid) > 1), 64'(0));
  endtask

  task automatic step(input logic stb, input logic v, input logic rs);
    @(negedge clk);
    bit_stb = stb; bit_val = v; rst_stb = rs;
    model(stb, v, rs);
    @(posedge clk);
    #2;
    compare_all();
    if (rs) chk("R1", "error after reset strobe", 64'(cmd_error), 64'(0));
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) step(1, b[i], 0);
  endtask

  task automatic send_rom(input logic [63:0] r);
    for (int i = 0; i < 64; i++) step(1, r[i], 0);
  endtask

  task automatic pulse_reset();
    step(0, 0, 1);
    step(0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare_all();
    chk("R1", "reset state error", 64'(cmd_error), 64'(0));
    @(negedge clk) rst_n = 1'b1;

    // R9: bit_val toggling without strobe
    for (int i = 0; i < 6; i++) step(0, i[0], 0);

    // R3 R5: read ROM then payload R8
    pulse_reset();
    send_byte(8'h33);
    send_rom(64'h5A_C0FFEE123456_28);
    send_byte(8'hA5); send_byte(8'h01); send_byte(8'hFE);

    // R3: match ROM and overdrive match
    pulse_reset(); send_byte(8'h55); send_rom(64'h0123456789ABCDEF); send_byte(8'h3C);
    pulse_reset(); send_byte(8'h69); send_rom(64'hFFFFFFFF00000001); send_byte(8'h80);

    // R3: skip variants go directly to payload
    pulse_reset(); send_byte(8'hCC); send_byte(8'h44); send_byte(8'hBE);
    pulse_reset(); send_byte(8'h3C); send_byte(8'h0F);

    // R6 R7: search with two empty groups
    pulse_reset(); send_byte(8'hF0);
    begin
      logic [63:0] pick = 64'hD1E2_F304_1526_3748;
      for (int g = 0; g < 64; g++) begin
        if (g == 5 || g == 63) begin
          step(1, 1, 0); step(1, 1, 0);
        end else begin
          step(1, ~pick[g], 0); step(1, pick[g], 0);
        end
        step(1, pick[g], 0);
        if (g == 20) step(0, 1, 0);
      end
    end
    send_byte(8'h7E);

    // R4: unknown command, raw error bytes, sticky until reset
    pulse_reset(); send_byte(8'hA5); send_byte(8'h12); send_byte(8'h34);
    step(0, 0, 0);

    // R1: partial command, partial ROM, partial search abandoned
    pulse_reset(); step(1, 1, 0); step(1, 1, 0); step(1, 0, 0);
    pulse_reset(); send_byte(8'hCC); send_byte(8'h99);
    pulse_reset(); send_byte(8'h33); for (int i = 0; i < 30; i++) step(1, i[1], 0);
    pulse_reset(); send_byte(8'hF0); for (int i = 0; i < 10; i++) step(1, 1, 0);
    pulse_reset(); send_byte(8'hCC); send_byte(8'h5C);

    // R1: reset strobe together with a bit strobe drops the bit
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 1);
    send_byte(8'h3C); send_byte(8'hC3);

    // R4: error cleared by reset; second unknown code
    pulse_reset(); send_byte(8'h00); send_byte(8'hFF);
    pulse_reset(); send_byte(8'hCC);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule